// File: doc/BRIEF.md
# Multiplying Successive-Approximation Converter Controller

This block sequences an 8-bit charge-redistribution converter and also uses that converter as a multiplier. Each conversion starts with a sampling phase. In that phase every capacitor switch of the array is gated by one bit of a stored coefficient. A capacitor that is left out contributes nothing to the held charge. The code that the search resolves is therefore the input scaled by the coefficient. A raw mode forces every gate on, and the block then acts as a plain converter.

After sampling, the block runs a binary search from the most significant bit down, one trial per clock. It drives the trial code onto the switches and keeps or drops each bit according to the comparator. In a final cycle the resolved code goes into an output register, and a one-cycle done pulse marks the new value. A conversion takes eleven clocks. The coefficient arrives over a serial shift port. Two extra sign bits in that register travel out with each result, so that downstream add-and-delay logic can form two's-complement products. The bench models the analog array and the comparator.

Top module: `msar_ctrl`

## Requirements
- R1: While reset is asserted, busy, done, samp_phase, cap_sw, result and res_sign are all zero.
- R2: When conv_start is high at a clock edge while busy is low, a conversion begins. For the two cycles that follow that edge, samp_phase is 1. With raw_mode=0, cap_sw during those cycles equals the magnitude field (coefficient bits 7:0), with switch i gated by bit i.
- R3: With raw_mode=1, cap_sw is all ones throughout sampling, whatever the coefficient holds.
- R4: In the eight cycles after sampling, the block tests bits 7 down to 0, one bit per cycle. In each cycle cap_sw shows the bits already resolved plus the current trial bit. The trial bit is kept when cmp_keep is 1 in that cycle and is cleared otherwise. The final code is the largest code not above the sampled level.
- R5: The cycle after the last trial loads the output register. done is 1 for exactly one cycle, 11 clock edges after the edge that accepted conv_start. result changes only together with that pulse.
- R6: The coefficient register is 10 bits wide. Each cycle with coef_shift=1 moves coef_sin into bit 0 and moves every other bit up by one place, so the first of ten bits shifted in ends at bit 9. Bits 7:0 hold the magnitude. Bits 9 and 8 come out as res_sign[1] and res_sign[0] alongside each result.
- R7: coef_shift has no effect while busy is high.
- R8: conv_start has no effect while busy is high. The running conversion finishes on time, and no new conversion follows it.
- R9: Between conversions, samp_phase is 0 and cap_sw is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Request to begin one conversion |
| raw_mode | input | 1 | 1 forces every sampling gate on |
| coef_shift | input | 1 | Shift enable for the coefficient register |
| coef_sin | input | 1 | Serial coefficient data bit |
| cmp_keep | input | 1 | Comparator: 1 when the array level does not exceed the held sample |
| samp_phase | output | 1 | Array connected to the input (sampling) |
| cap_sw | output | 8 | Capacitor switch controls, bit i for the weight-2^i capacitor |
| busy | output | 1 | Conversion in progress |
| result | output | 8 | Registered conversion code |
| res_sign | output | 2 | Sign bits delivered with result |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
A wrong value in the coefficient register shows up in the first sampling cycle of the next conversion, as a wrong cap_sw pattern. It appears again 11 cycles later as a wrong product. A broken trial counter or a broken keep decision shows up at cap_sw in the very trial cycle where it goes wrong, because the bench predicts every intermediate code from the expected product. A mistimed sequencer moves the done pulse off cycle 11, or lets samp_phase rise when it should not. Sweeping all raw inputs, plus a grid of magnitudes and inputs with changing sign bits, exposes each of these within one conversion.

// File: rtl/msar_pkg.sv
package msar_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2,
    PH_LOAD   = 2'd3
  } msar_phase_t;

endpackage

// File: rtl/msar_coef_sreg.sv
module msar_coef_sreg #(
  parameter int MAG_W  = 8,
  parameter int SIGN_W = 2,
  localparam int REG_W = MAG_W + SIGN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             sin,
  input  logic             freeze,
  output logic [REG_W-1:0] coef_q
);

  logic shift_ok;
  assign shift_ok = shift_en && !freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_q <= '0;
    end else if (shift_ok) begin
      coef_q <= {coef_q[REG_W-2:0], sin};
    end
  end

  // R7
  coef_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(coef_q));

endmodule

// File: rtl/msar_seq.sv
module msar_seq
  import msar_pkg::*;
#(
  parameter int SAMPLE_CYC = 2,
  parameter int NBITS      = 8,
  localparam int TOTAL     = SAMPLE_CYC + NBITS + 1,
  localparam int CNT_W     = $clog2(TOTAL),
  localparam int IDX_W     = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output msar_phase_t      phase,
  output logic             busy,
  output logic [IDX_W-1:0] bit_idx,
  output logic             start_acc,
  output logic             load_now
);

  localparam logic [CNT_W-1:0] LAST_CNT   = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] SAMP_END   = CNT_W'(SAMPLE_CYC);
  localparam logic [CNT_W-1:0] TRIAL_END  = CNT_W'(SAMPLE_CYC + NBITS);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  // position of the bit tested in trial step t, MSB first
  function automatic logic [IDX_W-1:0] trial_pos(input logic [CNT_W-1:0] c);
    int step;
    step = int'(c) - SAMPLE_CYC;
    return IDX_W'(NBITS - 1 - step);
  endfunction

  assign start_acc = start && !busy_q;
  assign busy      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == LAST_CNT) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (!busy_q)                phase = PH_IDLE;
    else if (cnt_q < SAMP_END)  phase = PH_SAMPLE;
    else if (cnt_q < TRIAL_END) phase = PH_TRIAL;
    else                        phase = PH_LOAD;
  end

  assign bit_idx  = (phase == PH_TRIAL) ? trial_pos(cnt_q) : '0;
  assign load_now = (phase == PH_LOAD);

  // R2
  samp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (phase == PH_SAMPLE));

  // R5
  load_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> !busy);

  // R8
  no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load_now) |=> busy);

endmodule

// File: rtl/msar_sar_reg.sv
module msar_sar_reg #(
  parameter int NBITS  = 8,
  localparam int IDX_W = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             trial_en,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             keep,
  output logic [NBITS-1:0] code_q,
  output logic [NBITS-1:0] trial_code
);

  function automatic logic [NBITS-1:0] one_hot(input logic [IDX_W-1:0] pos);
    logic [NBITS-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  logic [NBITS-1:0] probe;
  assign probe      = trial_en ? one_hot(bit_idx) : '0;
  assign trial_code = code_q | probe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (clear) begin
      code_q <= '0;
    end else if (trial_en) begin
      code_q[bit_idx] <= keep;
    end
  end

  // R4
  single_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trial_code ^ code_q));

  // R4
  lower_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trial_en |-> ((code_q & (probe - 1'b1)) == '0));

endmodule

// File: rtl/msar_ctrl.sv
module msar_ctrl
  import msar_pkg::*;
#(
  parameter int NBITS      = 8,
  parameter int SAMPLE_CYC = 2,
  parameter int SIGN_W     = 2,
  localparam int COEF_W    = NBITS + SIGN_W,
  localparam int IDX_W     = $clog2(NBITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic              raw_mode,
  input  logic              coef_shift,
  input  logic              coef_sin,
  input  logic              cmp_keep,
  output logic              samp_phase,
  output logic [NBITS-1:0]  cap_sw,
  output logic              busy,
  output logic [NBITS-1:0]  result,
  output logic [SIGN_W-1:0] res_sign,
  output logic              done
);

  msar_phase_t       phase;
  logic [IDX_W-1:0]  bit_idx;
  logic              start_acc;
  logic              load_now;
  logic              trial_en;
  logic [COEF_W-1:0] coef_q;
  logic [NBITS-1:0]  code_q;
  logic [NBITS-1:0]  trial_code;
  logic [NBITS-1:0]  result_q;
  logic [SIGN_W-1:0] sign_q;
  logic              done_q;

  msar_seq #(.SAMPLE_CYC(SAMPLE_CYC), .NBITS(NBITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (conv_start),
    .phase     (phase),
    .busy      (busy),
    .bit_idx   (bit_idx),
    .start_acc (start_acc),
    .load_now  (load_now)
  );

  msar_coef_sreg #(.MAG_W(NBITS), .SIGN_W(SIGN_W)) u_coef (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (coef_shift),
    .sin      (coef_sin),
    .freeze   (busy),
    .coef_q   (coef_q)
  );

  assign trial_en = (phase == PH_TRIAL);

  msar_sar_reg #(.NBITS(NBITS)) u_sar (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_acc),
    .trial_en   (trial_en),
    .bit_idx    (bit_idx),
    .keep       (cmp_keep),
    .code_q     (code_q),
    .trial_code (trial_code)
  );

  assign samp_phase = (phase == PH_SAMPLE);

  // one gate per capacitor: coefficient bit while sampling, search code after
  for (genvar gi = 0; gi < NBITS; gi++) begin : g_gate
    always_comb begin
      unique case (phase)
        PH_SAMPLE: cap_sw[gi] = raw_mode | coef_q[gi];
        PH_TRIAL:  cap_sw[gi] = trial_code[gi];
        default:   cap_sw[gi] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      sign_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= load_now;
      if (load_now) begin
        result_q <= code_q;
        sign_q   <= coef_q[COEF_W-1 -: SIGN_W];
      end
    end
  end

  assign result   = result_q;
  assign res_sign = sign_q;
  assign done     = done_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R3
  raw_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_mode && samp_phase) |-> (&cap_sw));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cap_sw == '0 && !samp_phase));

endmodule

// File: tb/test_msar_ctrl.sv
module test_msar_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       conv_start, raw_mode, coef_shift, coef_sin, cmp_keep;
  logic       samp_phase, busy, done;
  logic [7:0] cap_sw, result;
  logic [1:0] res_sign;

  int nvec = 0;
  int nerr = 0;

  logic [7:0] vin = '0;
  logic [7:0] s_held = '0;

  always #2 clk = ~clk;

  msar_ctrl i_msar_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .raw_mode(raw_mode),
    .coef_shift(coef_shift), .coef_sin(coef_sin), .cmp_keep(cmp_keep),
    .samp_phase(samp_phase), .cap_sw(cap_sw), .busy(busy), .result(result),
    .res_sign(res_sign), .done(done)
  );

  // analog array model: held charge is vin scaled by the enabled weight sum
  always @(negedge clk) begin
    if (samp_phase) s_held = 8'((int'(vin) * int'(cap_sw)) / 255);
  end
  assign cmp_keep = (cap_sw <= s_held);

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_coef(input logic [9:0] w);
    for (int i = 9; i >= 0; i--) begin
      coef_sin = w[i];
      coef_shift = 1'b1;
      @(posedge clk); #1;
    end
    coef_shift = 1'b0;
    coef_sin = 1'b0;
  endtask

  // one conversion; expected values from the requirements
  task automatic run_conv(input logic [7:0] v, input logic [9:0] w, input bit raw,
                          input bit poke_shift, input bit poke_start);
    int s_exp, mask, b, exp_sw;
    vin = v;
    raw_mode = raw;
    mask = raw ? 255 : int'(w[7:0]);
    s_exp = raw ? int'(v) : (int'(v) * int'(w[7:0])) / 255;
    conv_start = 1'b1;
    @(posedge clk); #1;
    conv_start = 1'b0;
    for (int m = 0; m <= 11; m++) begin
      if (m < 2) begin
        chk("R2 samp_phase in sampling", int'(samp_phase), 1);
        chk(raw ? "R3 raw sampling mask" : "R2 coefficient sampling mask", int'(cap_sw), mask);
      end else if (m < 10) begin
        b = 9 - m;
        exp_sw = (s_exp & ~((1 << (b + 1)) - 1)) | (1 << b);
        chk("R4 trial code on cap_sw", int'(cap_sw), exp_sw);
      end else if (m == 10) begin
        chk("R5 done not early", int'(done), 0);
      end else begin
        chk("R5 done after 11 edges", int'(done), 1);
        chk("R4 R5 result code", int'(result), s_exp);
        chk("R6 sign bits", int'(res_sign), int'(w[9:8]));
        chk("R9 idle switches", int'(cap_sw), 0);
      end
      if (m < 11) begin
        coef_shift = poke_shift && (m >= 2) && (m < 9);
        coef_sin = ~coef_sin;
        conv_start = poke_start && (m == 4 || m == 10);
        @(posedge clk); #1;
        coef_shift = 1'b0;
        conv_start = 1'b0;
      end
    end
    @(posedge clk); #1;
    chk("R5 done one cycle", int'(done), 0);
    chk("R8 no restart after busy start", int'(samp_phase) + int'(busy), 0);
    chk("R5 result held", int'(result), s_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R5 watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int mags [12] = '{0, 1, 2, 85, 127, 128, 170, 200, 254, 255, 15, 240};
    rst_n = 1'b0;
    conv_start = 1'b0; raw_mode = 1'b0; coef_shift = 1'b0; coef_sin = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset samp_phase", int'(samp_phase), 0);
    chk("R1 reset cap_sw", int'(cap_sw), 0);
    chk("R1 reset result", int'(result), 0);
    chk("R1 reset res_sign", int'(res_sign), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R3: exhaustive raw sweep over a coefficient that would zero the product
    load_coef(10'h300);
    for (int v = 0; v < 256; v++) run_conv(8'(v), 10'h300, 1'b1, 1'b0, 1'b0);

    // R2 R4 R6: magnitude and input grid with rotating signs
    for (int k = 0; k < 12; k++) begin
      logic [9:0] w;
      w = {2'(k), 8'(mags[k])};
      load_coef(w);
      for (int v = 0; v < 256; v += 15) run_conv(8'(v), w, 1'b0, 1'b0, 1'b0);
      run_conv(8'd255, w, 1'b0, 1'b0, 1'b0);
    end

    // R7: shifting during a conversion must leave the coefficient intact
    load_coef(10'h2B5);
    run_conv(8'd200, 10'h2B5, 1'b0, 1'b1, 1'b0);
    run_conv(8'd77, 10'h2B5, 1'b0, 1'b0, 1'b0);

    // R8: start requests while busy are dropped
    run_conv(8'd133, 10'h2B5, 1'b0, 1'b0, 1'b1);
    run_conv(8'd9, 10'h2B5, 1'b0, 1'b1, 1'b1);

    // R9: idle stays quiet
    repeat (5) @(posedge clk);
    #1;
    chk("R9 idle samp_phase", int'(samp_phase), 0);
    chk("R9 idle cap_sw", int'(cap_sw), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule